// File: doc/BRIEF.md
# Timer Baud-Tick and Square-Wave Generator

This block is the baud and clock-output mode of a 16-bit reload timer. The 16-bit count advances once per state, which is two oscillator clocks by default. It climbs to all ones and then wraps to a reload value that software sets. Each wrap can emit a one-cycle baud tick for the transmit side, the receive side, or both. The two sides are enabled separately, so either side may take its rate from another source. Each wrap can also toggle a square-wave pin, which gives a 50% duty-cycle clock at Fosc / (4 × (65536 − reload)).

The tick sources and the square-wave pin share the one reload value. A wrap in this mode never raises an overflow flag or an interrupt request. A falling edge on the trigger pin only sets an external event flag, so the pin can serve as an extra interrupt source. The edge never reloads the count. The reload value, which also presets the count, can only be written while the run input is low.

Top module: `tbg_top`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs are 0 after that edge, and the count and reload value are 0.
- R2: The count advances by one only on every DIV-th clock (DIV defaults to 2) while `run` is 1 and at least one source is selected (`tx_sel`, `rx_sel`, or square-wave mode). The prescaler restarts whenever this condition is false.
- R3: A step from count 0xFFFF loads the reload value, so wraps repeat every DIV × (65536 − reload) clocks.
- R4: `tx_tick` is a one-cycle pulse, registered, one clock after each wrap when `tx_sel` is 1. `rx_tick` behaves the same way with `rx_sel`, independently of `tx_tick`.
- R5: Square-wave mode is `ck_en`=1 and `cnt_mode`=0. In this mode `clk_out` toggles one clock after each wrap. Outside this mode `clk_out` is 0.
- R6: When `run` is 0, `rel_wr` loads both the reload value and the count from `rel_din`. When `run` is 1, `rel_wr` is ignored.
- R7: When `ext_en` is 1, a falling edge of `trig_in` (1 at one edge, 0 at the next) sets `ext_flag` one clock later. The edge leaves the count untouched.
- R8: `ext_clr` clears `ext_flag`. A set in the same cycle wins over the clear. With `ext_en`=0, edges do not set the flag.
- R9: When `run` is 0, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Run enable |
| tx_sel | input | 1 | Use wraps as transmit baud ticks |
| rx_sel | input | 1 | Use wraps as receive baud ticks |
| ck_en | input | 1 | Square-wave output enable |
| cnt_mode | input | 1 | Counter/timer select; must be 0 for square-wave output |
| ext_en | input | 1 | Enable trigger-pin event flag |
| trig_in | input | 1 | Trigger pin |
| ext_clr | input | 1 | Clear event flag |
| rel_wr | input | 1 | Reload write strobe |
| rel_din | input | 16 | Reload write data |
| tx_tick | output | 1 | Transmit baud tick |
| rx_tick | output | 1 | Receive baud tick |
| clk_out | output | 1 | 50% square wave |
| ext_flag | output | 1 | Trigger event flag |

## Verification
Any fault in the count, the prescaler phase or the stored reload value shows up at the ports as a tick or a `clk_out` edge that arrives on the wrong clock. A reference model flags the mismatch at the first wrong wrap, which is at most DIV × (65536 − reload) clocks after the fault. A reload accepted while running, or a reload caused by a trigger edge, moves the next wrap and is caught the same way. A fault in the flag logic is visible on `ext_flag` within one clock.

// File: rtl/tbg_pkg.sv
package tbg_pkg;
  localparam int unsigned TBG_CNT_W = 16;
  localparam int unsigned TBG_DIV   = 2;
endpackage

// File: rtl/tbg_prescale.sv
module tbg_prescale #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic step
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (rst || !go)      ph_q <= '0;
    else if (ph_q == LAST) ph_q <= '0;
    else                 ph_q <= ph_q + 1'b1;
  end

  assign step = go && (ph_q == LAST);
endmodule

// File: rtl/tbg_counter.sv
module tbg_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         step,
  input  logic         wr,
  input  logic [W-1:0] din,
  output logic         roll,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] rel_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rel_q <= '0;
    end else if (!run && wr) begin
      cnt_q <= din;
      rel_q <= din;
    end else if (step) begin
      cnt_q <= (cnt_q == '1) ? rel_q : cnt_q + 1'b1;
    end
  end

  assign roll = step && (cnt_q == '1);
endmodule

// File: rtl/tbg_trigger.sv
module tbg_trigger (
  input  logic clk,
  input  logic rst,
  input  logic ext_en,
  input  logic trig_in,
  input  logic ext_clr,
  output logic ext_flag
);
  logic trig_q;
  logic fall;

  assign fall = trig_q && !trig_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q   <= 1'b0;
      ext_flag <= 1'b0;
    end else begin
      trig_q <= trig_in;
      if (ext_en && fall) ext_flag <= 1'b1;
      else if (ext_clr)   ext_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/tbg_top.sv
module tbg_top
  import tbg_pkg::*;
#(
  parameter int unsigned CNT_W = TBG_CNT_W,
  parameter int unsigned DIV   = TBG_DIV
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tx_sel,
  input  logic             rx_sel,
  input  logic             ck_en,
  input  logic             cnt_mode,
  input  logic             ext_en,
  input  logic             trig_in,
  input  logic             ext_clr,
  input  logic             rel_wr,
  input  logic [CNT_W-1:0] rel_din,
  output logic             tx_tick,
  output logic             rx_tick,
  output logic             clk_out,
  output logic             ext_flag
);
  logic             sq_mode;
  logic             active;
  logic             step_w;
  logic             roll_w;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] rel_w;

  assign sq_mode = ck_en && !cnt_mode;
  assign active  = tx_sel || rx_sel || sq_mode;

  tbg_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .go(run && active), .step(step_w)
  );

  tbg_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .step(step_w),
    .wr(rel_wr), .din(rel_din), .roll(roll_w),
    .cnt_q(cnt_w), .rel_q(rel_w)
  );

  tbg_trigger u_trg (
    .clk(clk), .rst(rst), .ext_en(ext_en), .trig_in(trig_in),
    .ext_clr(ext_clr), .ext_flag(ext_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_tick <= 1'b0;
      rx_tick <= 1'b0;
      clk_out <= 1'b0;
    end else begin
      tx_tick <= roll_w && tx_sel;
      rx_tick <= roll_w && rx_sel;
      if (!sq_mode)    clk_out <= 1'b0;
      else if (roll_w) clk_out <= !clk_out;
    end
  end
endmodule

// File: rtl/tbg_chk.sv
module tbg_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             ck_en,
  input logic             cnt_mode,
  input logic             ext_en,
  input logic             trig_in,
  input logic             rel_wr,
  input logic             roll,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] rel,
  input logic             tx_tick,
  input logic             clk_out,
  input logic             ext_flag
);
  // R4
  tick_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_tick |=> !tx_tick);

  // R5
  sq_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_out) |-> $past(roll));

  // R5
  sq_off_chk: assert property (@(posedge clk) disable iff (rst)
    !(ck_en && !cnt_mode) |=> !clk_out);

  // R6
  rel_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (run && rel_wr) |=> $stable(rel));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !rel_wr) |=> $stable(cnt));

  // R7
  edge_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(trig_in) && !trig_in && ext_en) |=> ext_flag);
endmodule

bind tbg_top tbg_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .run(run), .ck_en(ck_en), .cnt_mode(cnt_mode),
  .ext_en(ext_en), .trig_in(trig_in), .rel_wr(rel_wr), .roll(roll_w),
  .cnt(cnt_w), .rel(rel_w), .tx_tick(tx_tick), .clk_out(clk_out),
  .ext_flag(ext_flag)
);

// File: tb/sim_tbg_top.sv
`timescale 1ns/1ps
module sim_tbg_top;
  localparam int DIV = 2;

  logic clk = 1'b0;
  logic rst, run, tx_sel, rx_sel, ck_en, cnt_mode, ext_en, trig_in, ext_clr, rel_wr;
  logic [15:0] rel_din;
  logic tx_tick, rx_tick, clk_out, ext_flag;

  int tests = 0;
  int fails = 0;
  string tag = "R1";

  // reference state
  int m_ph, m_cnt, m_rel;
  bit m_tx, m_rx, m_ck, m_trq, m_flag;

  always #2 clk = ~clk;

  tbg_top u0 (
    .clk(clk), .rst(rst), .run(run), .tx_sel(tx_sel), .rx_sel(rx_sel),
    .ck_en(ck_en), .cnt_mode(cnt_mode), .ext_en(ext_en), .trig_in(trig_in),
    .ext_clr(ext_clr), .rel_wr(rel_wr), .rel_din(rel_din),
    .tx_tick(tx_tick), .rx_tick(rx_tick), .clk_out(clk_out), .ext_flag(ext_flag)
  );

  always @(posedge clk) begin
    bit sq, go, stp, wrap, fall;
    if (rst) begin
      m_ph = 0; m_cnt = 0; m_rel = 0;
      m_tx = 0; m_rx = 0; m_ck = 0; m_trq = 0; m_flag = 0;
    end else begin
      sq   = ck_en && !cnt_mode;
      go   = run && (tx_sel || rx_sel || sq);
      stp  = go && (m_ph == DIV - 1);
      wrap = stp && (m_cnt == 16'hFFFF);
      fall = m_trq && !trig_in;
      m_ph = (!go || m_ph == DIV - 1) ? 0 : m_ph + 1;
      if (!run && rel_wr) begin
        m_rel = rel_din; m_cnt = rel_din;
      end else if (stp) begin
        m_cnt = wrap ? m_rel : m_cnt + 1;
      end
      m_tx = wrap && tx_sel;
      m_rx = wrap && rx_sel;
      m_ck = !sq ? 1'b0 : (wrap ? !m_ck : m_ck);
      if (ext_en && fall) m_flag = 1;
      else if (ext_clr)   m_flag = 0;
      m_trq = trig_in;
    end
  end

  task automatic chk(input string t, input string nm, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, nm, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk(tag, "tx_tick", tx_tick, m_tx);
    chk(tag, "rx_tick", rx_tick, m_rx);
    chk(tag, "clk_out", clk_out, m_ck);
    chk(tag, "ext_flag", ext_flag, m_flag);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int gap;
    rst = 1; run = 0; tx_sel = 0; rx_sel = 0; ck_en = 0; cnt_mode = 0;
    ext_en = 0; trig_in = 0; ext_clr = 0; rel_wr = 0; rel_din = 0;
    cyc(3);
    tag = "R1";
    chk("R1", "reset outputs", {tx_tick, rx_tick, clk_out, ext_flag}, 0);
    rst = 0;
    // load reload while stopped (R6)
    tag = "R6";
    rel_din = 16'hFFF0; rel_wr = 1; cyc(1); rel_wr = 0;
    // transmit ticks, measure period (R3, R2, R4)
    tag = "R3";
    tx_sel = 1; run = 1;
    while (tx_tick !== 1'b1) cyc(1);
    gap = 0;
    do begin cyc(1); gap++; end while (tx_tick !== 1'b1);
    chk("R3", "wrap period", gap, DIV * 16);
    tag = "R4";
    rx_sel = 1; cyc(80);
    tx_sel = 0; cyc(80);
    chk("R4", "tx idle with tx_sel=0", tx_tick, 0);
    // square wave (R5)
    tag = "R5";
    ck_en = 1; cyc(200);
    cnt_mode = 1; cyc(40);
    chk("R5", "clk_out held low in counter mode", clk_out, 0);
    cnt_mode = 0; cyc(100);
    // write while running ignored (R6)
    tag = "R6";
    rel_din = 16'hFFFD; rel_wr = 1; cyc(3); rel_wr = 0; cyc(120);
    // trigger edge, no reload (R7)
    tag = "R7";
    ext_en = 1; trig_in = 1; cyc(5); trig_in = 0; cyc(2);
    chk("R7", "flag after edge", ext_flag, 1);
    cyc(60);
    // clear, set-wins, disabled edge (R8)
    tag = "R8";
    ext_clr = 1; cyc(1); ext_clr = 0; cyc(1);
    chk("R8", "flag cleared", ext_flag, 0);
    trig_in = 1; cyc(2); trig_in = 0; ext_clr = 1; cyc(1); ext_clr = 0; cyc(1);
    chk("R8", "set wins over clear", ext_flag, 1);
    ext_clr = 1; cyc(1); ext_clr = 0; ext_en = 0;
    trig_in = 1; cyc(2); trig_in = 0; cyc(3);
    chk("R8", "edge ignored when disabled", ext_flag, 0);
    // hold while stopped (R9)
    tag = "R9";
    run = 0; cyc(50);
    run = 1; cyc(100);
    // no source selected: count frozen (R2)
    tag = "R2";
    rx_sel = 0; ck_en = 0; cyc(50);
    rx_sel = 1; cyc(100);
    // new reload while stopped, all-ones reload (R6, R3)
    tag = "R6";
    run = 0; rel_din = 16'hFFFF; rel_wr = 1; cyc(1); rel_wr = 0;
    run = 1; tx_sel = 1; ck_en = 1; cyc(60);
    // reset mid-run (R1)
    tag = "R1";
    rst = 1; cyc(1);
    chk("R1", "reset mid-run", {tx_tick, rx_tick, clk_out, ext_flag}, 0);
    rst = 0; cyc(30);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule